// File: doc/BRIEF.md
# Modulo-15 Residue Generator

This block produces the residue of a 16-bit operand with respect to the check modulus 2^4 − 1 = 15. A concurrent error checker for an arithmetic unit uses it: the residues of the operands and of the result are formed alongside the main datapath and then compared elsewhere. The comparison itself is not part of this block.

No divider is used. Each power 2^4k is congruent to 1 modulo 15, so the operand's 4-bit digits can simply be added modulo 15. The four digits pass through a carry-save reduction built from two 3:2 stages, which together form a 4:2 compressor. In each stage the carry leaving the top bit re-enters at bit 0. The resulting pair of 4-bit vectors is summed by a 4-bit end-around-carry adder. The all-ones pattern is a second code for zero, and the adder maps it to 0000. Both the operand and the residue are purely combinational.

Top module: `mod_residue_gen`

## Requirements
- R1: For every 16-bit operand value v, res_o equals v mod 15.
- R2: The operand is taken as four 4-bit digits at bits [3:0], [7:4], [11:8] and [15:12]. All four have equal weight, so a digit value d placed alone at any one of these positions gives the residue d mod 15.
- R3: The four digits are reduced to two 4-bit vectors whose sum is congruent, modulo 15, to the sum of the digits. A carry out of bit 3 of a reduction stage re-enters at bit 0. Operands whose digits are all 0xE or 0xF still give the correct residue.
- R4: When the final 4-bit addition carries out of bit 3, that carry is added back at bit 0. An example is operand 0xEEEE, which has residue 11.
- R5: res_o never shows 1111. Any operand that is a multiple of 15 gives 0000, including 0x000F, 0x00F0, 0x0F00, 0xF000 and 0xFFFF.
- R6: res_o depends on op_i alone, with no clock and no stored state. It settles within the same time step in which op_i changes, and op_i = 0 gives 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 16 | Operand whose residue is wanted |
| res_o | output | 4 | Residue of op_i modulo 15, zero encoded as 0000 |

## Verification
The hardest situation to reach is the one where end-around carries fire in both compressor stages and then again in the final adder, and the adder's sum lands on the redundant all-ones code that must be rewritten to zero. Random operands rarely combine these. The stimulus forces them with a sweep over every operand whose digits are all 0xE or 0xF, together with multiples of 15 and single-digit 0xF operands. A full sweep of all 65,536 operand values then confirms the residue everywhere.

// File: rtl/rg_pkg.sv
package rg_pkg;
    localparam int unsigned RG_OP_W = 16;
    localparam int unsigned RG_DIGIT_W = 4;

    function automatic int unsigned rg_modulus(input int unsigned digit_w);
        return (32'd1 << digit_w) - 32'd1;
    endfunction
endpackage

// File: rtl/rg_csa_eac.sv
module rg_csa_eac #(
    parameter int unsigned C = 4
) (
    input  logic [C-1:0] x_i,
    input  logic [C-1:0] y_i,
    input  logic [C-1:0] z_i,
    output logic [C-1:0] sum_o,
    output logic [C-1:0] car_o
);
    localparam int unsigned MODV = rg_pkg::rg_modulus(C);

    typedef struct packed {
        logic [C-1:0] sum_d;
        logic [C-1:0] maj_d;
    } csa_t;

    csa_t nx;

    always_comb begin
        nx.sum_d = x_i ^ y_i ^ z_i;
        nx.maj_d = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
        sum_o    = nx.sum_d;
        // weight 2^C folds back to weight 1 modulo 2^C-1
        car_o    = {nx.maj_d[C-2:0], nx.maj_d[C-1]};
    end

    // R3: stage keeps the value modulo 2^C-1
    always_comb begin
        if (!$isunknown({x_i, y_i, z_i, sum_o, car_o})) begin
            p_stage_keeps_mod_r3: assert (((32'(x_i) + 32'(y_i) + 32'(z_i)) % MODV)
                                          == ((32'(sum_o) + 32'(car_o)) % MODV))
                else $error("stage residue mismatch");
        end
    end
endmodule

// File: rtl/rg_compress.sv
module rg_compress #(
    parameter int unsigned C = 4,
    parameter int unsigned N = 4
) (
    input  logic [N*C-1:0] dig_i,
    output logic [C-1:0]   vs_o,
    output logic [C-1:0]   vc_o
);
    localparam int unsigned MODV = rg_pkg::rg_modulus(C);

    generate
        if (N == 1) begin : g_one
            assign vs_o = dig_i[C-1:0];
            assign vc_o = '0;
        end else if (N == 2) begin : g_two
            assign vs_o = dig_i[C-1:0];
            assign vc_o = dig_i[2*C-1:C];
        end else begin : g_chain
            logic [C-1:0] acc_s [N-1];
            logic [C-1:0] acc_c [N-1];
            assign acc_s[0] = dig_i[C-1:0];
            assign acc_c[0] = dig_i[2*C-1:C];
            for (genvar k = 0; k < N - 2; k++) begin : g_stage
                rg_csa_eac #(.C(C)) u_csa (
                    .x_i  (acc_s[k]),
                    .y_i  (acc_c[k]),
                    .z_i  (dig_i[(k+2)*C +: C]),
                    .sum_o(acc_s[k+1]),
                    .car_o(acc_c[k+1])
                );
            end
            assign vs_o = acc_s[N-2];
            assign vc_o = acc_c[N-2];
        end
    endgenerate

    // R3: the pair of vectors carries the digit sum modulo 2^C-1
    always_comb begin
        int unsigned tot;
        tot = 0;
        for (int k = 0; k < int'(N); k++) begin
            tot = tot + 32'(dig_i[k*C +: C]);
        end
        if (!$isunknown({dig_i, vs_o, vc_o})) begin
            p_pair_keeps_mod_r3: assert ((tot % MODV) == ((32'(vs_o) + 32'(vc_o)) % MODV))
                else $error("compressor residue mismatch");
        end
    end
endmodule

// File: rtl/rg_eac_add.sv
module rg_eac_add #(
    parameter int unsigned C = 4
) (
    input  logic [C-1:0] a_i,
    input  logic [C-1:0] b_i,
    output logic [C-1:0] r_o
);
    localparam int unsigned MODV = rg_pkg::rg_modulus(C);

    typedef struct packed {
        logic [C:0]   raw_d;
        logic [C-1:0] wrap_d;
        logic [C-1:0] norm_d;
    } add_t;

    add_t nx;

    always_comb begin
        nx.raw_d  = {1'b0, a_i} + {1'b0, b_i};
        // a carry out is worth 2^C, which is 1 modulo 2^C-1; a second carry cannot occur
        nx.wrap_d = nx.raw_d[C-1:0] + {{(C-1){1'b0}}, nx.raw_d[C]};
        nx.norm_d = (&nx.wrap_d) ? '0 : nx.wrap_d;
        r_o       = nx.norm_d;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, r_o})) begin
            // R4: end-around sum is the true modular sum
            p_eac_sum_r4: assert (32'(r_o) == ((32'(a_i) + 32'(b_i)) % MODV))
                else $error("end-around sum wrong");
            // R5: redundant zero code never leaves the adder
            p_no_all_ones_r5: assert (r_o != {C{1'b1}})
                else $error("all-ones residue emitted");
        end
    end
endmodule

// File: rtl/mod_residue_gen.sv
module mod_residue_gen #(
    parameter int unsigned OP_W = rg_pkg::RG_OP_W,
    parameter int unsigned CHK_C = rg_pkg::RG_DIGIT_W
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [CHK_C-1:0] res_o
);
    localparam int unsigned NDIG  = (OP_W + CHK_C - 1) / CHK_C;
    localparam int unsigned PAD_W = NDIG * CHK_C;
    localparam int unsigned MODV  = rg_pkg::rg_modulus(CHK_C);

    logic [PAD_W-1:0] dig_d;
    logic [CHK_C-1:0] vs_d;
    logic [CHK_C-1:0] vc_d;

    always_comb begin
        dig_d = '0;
        dig_d[OP_W-1:0] = op_i;
    end

    rg_compress #(.C(CHK_C), .N(NDIG)) u_cmp (
        .dig_i(dig_d),
        .vs_o (vs_d),
        .vc_o (vc_d)
    );

    rg_eac_add #(.C(CHK_C)) u_add (
        .a_i(vs_d),
        .b_i(vc_d),
        .r_o(res_o)
    );

    always_comb begin
        if (!$isunknown({op_i, res_o})) begin
            // R1: port-level residue
            p_residue_r1: assert (32'(res_o) == (32'(op_i) % MODV))
                else $error("residue wrong");
            // R5: residue stays inside the modulus range
            p_in_range_r5: assert (32'(res_o) < MODV)
                else $error("residue out of range");
        end
    end
endmodule

// File: tb/mod_residue_gen_test.sv
module mod_residue_gen_test;
    logic        clk;
    logic        rst_n;
    logic [15:0] op;
    logic [3:0]  res;
    int          n_checks;
    int          n_errors;
    int          cyc;
    bit          reported;

    mod_residue_gen uut (
        .op_i (op),
        .res_o(res)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            report();
        end
    end

    function automatic logic [3:0] ref_res(input logic [15:0] v);
        return 4'(32'(v) % 15);
    endfunction

    task automatic check_val(input logic [15:0] v, input logic [3:0] expv, input string tag);
        op = v;
        #1;
        n_checks = n_checks + 1;
        if (res !== expv) begin
            n_errors = n_errors + 1;
            $display("FAIL %s op=%h actual=%0d expected=%0d", tag, v, res, expv);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op = 16'h0;
        repeat (3) @(negedge clk);
        check_val(16'h0000, 4'd0, "R6 zero operand in reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_zero_codes();
        @(negedge clk);
        check_val(16'hFFFF, 4'd0, "R5 all-ones operand");
        check_val(16'h000F, 4'd0, "R5 digit0 F");
        check_val(16'h00F0, 4'd0, "R5 digit1 F");
        check_val(16'h0F00, 4'd0, "R5 digit2 F");
        check_val(16'hF000, 4'd0, "R5 digit3 F");
        check_val(16'h0F0F, 4'd0, "R5 two F digits");
    endtask

    task automatic t_multiples();
        @(negedge clk);
        for (int k = 0; k <= 4369; k += 17) begin
            check_val(16'(k * 15), 4'd0, "R5 multiple of 15");
        end
        check_val(16'(4369 * 15), 4'd0, "R5 largest multiple");
        check_val(16'(1234 * 15 + 7), 4'd7, "R1 multiple plus 7");
    endtask

    task automatic t_digit_move();
        @(negedge clk);
        for (int d = 1; d < 16; d++) begin
            for (int p = 0; p < 4; p++) begin
                check_val(16'(d << (4 * p)), 4'(d % 15), "R2 single digit position");
            end
        end
    endtask

    task automatic t_heavy_carry();
        @(negedge clk);
        for (int m = 0; m < 16; m++) begin
            logic [15:0] v;
            for (int p = 0; p < 4; p++) begin
                v[4*p +: 4] = m[p] ? 4'hF : 4'hE;
            end
            check_val(v, ref_res(v), "R3 E/F digit sweep");
        end
        check_val(16'hEEEE, 4'd11, "R4 end-around carry 0xEEEE");
        check_val(16'h8888, 4'd2, "R4 end-around carry 0x8888");
        check_val(16'h0077, 4'd14, "R4 carry then 14");
    endtask

    task automatic t_comb();
        @(negedge clk);
        #3;
        check_val(16'h1234, ref_res(16'h1234), "R6 settle mid-cycle A");
        check_val(16'hBEEF, ref_res(16'hBEEF), "R6 settle mid-cycle B");
        check_val(16'h0000, 4'd0, "R6 back to zero");
    endtask

    task automatic t_random();
        @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            check_val(v, ref_res(v), "R1 random operand");
        end
    endtask

    task automatic t_sweep();
        @(negedge clk);
        for (int v = 0; v < 65536; v++) begin
            check_val(16'(v), ref_res(16'(v)), "R1 exhaustive sweep");
        end
    endtask

    initial begin
        n_checks = 0;
        n_errors = 0;
        cyc = 0;
        reported = 1'b0;
        t_reset();
        t_zero_codes();
        t_multiples();
        t_digit_move();
        t_heavy_carry();
        t_comb();
        t_random();
        t_sweep();
        @(negedge clk);
        report();
    end
endmodule